// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block sits in the decode stage of a 16-bit processor with sixteen registers and a two-operand instruction format. It takes the instruction word and works out where each operand lives. For each operand it reports one of three things: a register number, a memory effective address, or an immediate value. It also says whether the source addressing needs a write-back of an incremented pointer. For the whole instruction it reports the length in words and the number of execution cycles that the source/destination mode pair costs.

Symbolic, absolute and immediate addressing have no encodings of their own. They come from the ordinary indexed and post-increment encodings when the base is register 0 (the program counter) or register 2 (the status register). The resolver applies these special readings itself. The decode stage feeds it the following: the instruction word, the address of that instruction, the register-file values read for the two register fields, and the two program words that follow the instruction. The results are registered and appear one cycle after `in_valid`.

Top module: `amr_resolver`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted instruction, `out_valid` is 0 and every other output is 0.
- R2: A word presented with `in_valid`=1 produces its results on the outputs one clock later, with `out_valid`=1. In a cycle with `in_valid`=0, `out_valid` falls to 0 and all other outputs keep their last values.
- R3: Field positions are: instr[11:8] source register, instr[7] destination mode, instr[5:4] source mode, instr[3:0] destination register. Source kind codes are 0 register, 1 memory, 2 immediate. Source mode 00 gives kind 0 with `src_reg` = the source field. Source mode 10 gives kind 1 with address = the source register value, or `pc`+2 when the register is 0.
- R4: Source mode 01 gives kind 1 with address = base + `ext0`. The base is the register value, or `pc`+2 when the register is 0 (symbolic), or zero when the register is 2 (absolute).
- R5: Source mode 11 with a register other than 0 gives kind 1 with address = the register value. It raises `wb_en` with `wb_reg` = the source register and `wb_val` = value+1 when `byte_op`=1, or value+2 when `byte_op`=0. In every other case `wb_en`, `wb_reg` and `wb_val` are 0.
- R6: Source mode 11 with register 0 gives kind 2 (immediate) with `src_imm` = `ext0` and no write-back. `src_imm` is 0 for any other kind.
- R7: Destination mode 0 gives `dst_kind` 0 with `dst_reg` = the destination field and `dst_addr` = 0. Destination mode 1 gives `dst_kind` 1 with address = base + X. X is `ext1` when the source used an extension word and `ext0` otherwise. The base is the destination register value, or zero for register 2, or the address of the word holding X (`pc`+2, or `pc`+4 after a source extension) for register 0.
- R8: `len_words` = 1, plus 1 if the source mode is 01 or is 11 with register 0, plus 1 if the destination mode is 1.
- R9: With a register destination other than register 0, `cycles` is 1 for source mode 00, 2 for modes 10 and 11, and 3 for mode 01.
- R10: With destination mode 1, `cycles` is 4 for source mode 00, 5 for modes 10 and 11, and 6 for mode 01.
- R11: With a register destination equal to register 0, `cycles` is 2 for source modes 00 and 10, and 3 for modes 01 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the presented instruction this cycle |
| instr | input | 16 | Two-operand instruction word |
| pc | input | 16 | Address of the instruction word |
| src_val | input | 16 | Register-file value of the source register field |
| dst_val | input | 16 | Register-file value of the destination register field |
| ext0 | input | 16 | First program word after the instruction |
| ext1 | input | 16 | Second program word after the instruction |
| byte_op | input | 1 | 1 for a byte operation, 0 for a word operation |
| out_valid | output | 1 | Results below belong to an accepted instruction |
| src_kind | output | 2 | Source kind: 0 register, 1 memory, 2 immediate |
| src_reg | output | 4 | Source register number |
| src_addr | output | 16 | Source effective address (memory kind only) |
| src_imm | output | 16 | Immediate operand (immediate kind only) |
| dst_kind | output | 1 | Destination kind: 0 register, 1 memory |
| dst_reg | output | 4 | Destination register number |
| dst_addr | output | 16 | Destination effective address (memory kind only) |
| wb_en | output | 1 | Pointer post-increment write-back request |
| wb_reg | output | 4 | Register to write back |
| wb_val | output | 16 | Incremented pointer value |
| len_words | output | 2 | Instruction length in words (1 to 3) |
| cycles | output | 3 | Execution cycle count for the mode pair |

## Verification
A wrong special-case decode of register 0 or register 2 shows up one cycle after the instruction is accepted. It appears as an address off by the program-counter offset, or as a base that is not zero, in `src_addr` or `dst_addr`. A mistake in the order of the extension words shows only when both operands take one: the destination address then uses the source's word and the wrong `pc` offset. A wrong post-increment step or a cycle-table error lands in the same output cycle, on `wb_val` or `cycles`. A broken hold path shows on the first idle cycle as changed outputs.

// File: rtl/amr_pkg.sv
package amr_pkg;
  localparam int DATA_W = 16;
  localparam int RIDX_W = 4;
  localparam int CYC_W  = 3;
  localparam int LEN_W  = 2;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_MEM = 2'd1,
    SRC_IMM = 2'd2
  } src_kind_e;

  typedef enum logic {
    DST_REG = 1'b0,
    DST_MEM = 1'b1
  } dst_kind_e;

  localparam logic [RIDX_W-1:0] PC_IDX = 4'd0;
  localparam logic [RIDX_W-1:0] SR_IDX = 4'd2;
endpackage

// File: rtl/amr_src_resolve.sv
module amr_src_resolve
  import amr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [1:0]        mode,
  input  logic [RIDX_W-1:0] sreg,
  input  logic [DW-1:0]     reg_val,
  input  logic [DW-1:0]     pc_val,
  input  logic [DW-1:0]     ext_word,
  input  logic              byte_op,
  output src_kind_e         kind,
  output logic [DW-1:0]     addr,
  output logic [DW-1:0]     imm,
  output logic              needs_ext,
  output logic              wb_en,
  output logic [DW-1:0]     wb_val
);
  localparam logic [DW-1:0] STEP_B = DW'(1);
  localparam logic [DW-1:0] STEP_W = DW'(2);

  logic [DW-1:0] after_pc;
  logic [DW-1:0] idx_base;

  assign after_pc = pc_val + STEP_W;

  always_comb begin
    if (sreg == PC_IDX)      idx_base = after_pc;
    else if (sreg == SR_IDX) idx_base = '0;
    else                     idx_base = reg_val;
  end

  always_comb begin
    kind      = SRC_REG;
    addr      = '0;
    imm       = '0;
    needs_ext = 1'b0;
    wb_en     = 1'b0;
    wb_val    = '0;
    unique case (mode)
      2'b00: kind = SRC_REG;
      2'b01: begin
        kind      = SRC_MEM;
        needs_ext = 1'b1;
        addr      = idx_base + ext_word;
      end
      2'b10: begin
        kind = SRC_MEM;
        addr = (sreg == PC_IDX) ? after_pc : reg_val;
      end
      default: begin
        if (sreg == PC_IDX) begin
          kind      = SRC_IMM;
          imm       = ext_word;
          needs_ext = 1'b1;
        end else begin
          kind   = SRC_MEM;
          addr   = reg_val;
          wb_en  = 1'b1;
          wb_val = reg_val + (byte_op ? STEP_B : STEP_W);
        end
      end
    endcase
  end
endmodule

// File: rtl/amr_dst_resolve.sv
module amr_dst_resolve
  import amr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              ad,
  input  logic [RIDX_W-1:0] dreg,
  input  logic [DW-1:0]     reg_val,
  input  logic [DW-1:0]     pc_val,
  input  logic              src_ext,
  input  logic [DW-1:0]     ext0,
  input  logic [DW-1:0]     ext1,
  output dst_kind_e         kind,
  output logic [DW-1:0]     addr,
  output logic              needs_ext
);
  logic [DW-1:0] x_word;
  logic [DW-1:0] x_loc;
  logic [DW-1:0] base;

  assign x_word = src_ext ? ext1 : ext0;
  assign x_loc  = pc_val + (src_ext ? DW'(4) : DW'(2));

  always_comb begin
    if (dreg == PC_IDX)      base = x_loc;
    else if (dreg == SR_IDX) base = '0;
    else                     base = reg_val;
  end

  always_comb begin
    if (ad) begin
      kind      = DST_MEM;
      addr      = base + x_word;
      needs_ext = 1'b1;
    end else begin
      kind      = DST_REG;
      addr      = '0;
      needs_ext = 1'b0;
    end
  end
endmodule

// File: rtl/amr_cost.sv
module amr_cost
  import amr_pkg::*;
(
  input  logic [1:0]       src_mode,
  input  logic             ad,
  input  logic             dst_is_pc,
  input  logic             src_ext,
  input  logic             dst_ext,
  output logic [LEN_W-1:0] len_words,
  output logic [CYC_W-1:0] cycles
);
  assign len_words = LEN_W'(1) + LEN_W'(src_ext) + LEN_W'(dst_ext);

  always_comb begin
    if (ad) begin
      unique case (src_mode)
        2'b00:   cycles = CYC_W'(4);
        2'b01:   cycles = CYC_W'(6);
        default: cycles = CYC_W'(5);
      endcase
    end else if (dst_is_pc) begin
      unique case (src_mode)
        2'b00, 2'b10: cycles = CYC_W'(2);
        default:      cycles = CYC_W'(3);
      endcase
    end else begin
      unique case (src_mode)
        2'b00:   cycles = CYC_W'(1);
        2'b01:   cycles = CYC_W'(3);
        default: cycles = CYC_W'(2);
      endcase
    end
  end
endmodule

// File: rtl/amr_resolver.sv
module amr_resolver
  import amr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       instr,
  input  logic [DW-1:0]     pc,
  input  logic [DW-1:0]     src_val,
  input  logic [DW-1:0]     dst_val,
  input  logic [DW-1:0]     ext0,
  input  logic [DW-1:0]     ext1,
  input  logic              byte_op,
  output logic              out_valid,
  output logic [1:0]        src_kind,
  output logic [RIDX_W-1:0] src_reg,
  output logic [DW-1:0]     src_addr,
  output logic [DW-1:0]     src_imm,
  output logic              dst_kind,
  output logic [RIDX_W-1:0] dst_reg,
  output logic [DW-1:0]     dst_addr,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_reg,
  output logic [DW-1:0]     wb_val,
  output logic [LEN_W-1:0]  len_words,
  output logic [CYC_W-1:0]  cycles
);
  // instruction fields
  logic [RIDX_W-1:0] f_sreg, f_dreg;
  logic [1:0]        f_smode;
  logic              f_ad;

  assign f_sreg  = instr[11:8];
  assign f_ad    = instr[7];
  assign f_smode = instr[5:4];
  assign f_dreg  = instr[3:0];

  src_kind_e         s_kind;
  logic [DW-1:0]     s_addr, s_imm, s_wbv;
  logic              s_ext, s_wb;
  dst_kind_e         d_kind;
  logic [DW-1:0]     d_addr;
  logic              d_ext;
  logic [LEN_W-1:0]  n_len;
  logic [CYC_W-1:0]  n_cyc;

  amr_src_resolve #(.DW(DW)) u_src (
    .mode(f_smode), .sreg(f_sreg), .reg_val(src_val), .pc_val(pc),
    .ext_word(ext0), .byte_op(byte_op), .kind(s_kind), .addr(s_addr),
    .imm(s_imm), .needs_ext(s_ext), .wb_en(s_wb), .wb_val(s_wbv)
  );

  amr_dst_resolve #(.DW(DW)) u_dst (
    .ad(f_ad), .dreg(f_dreg), .reg_val(dst_val), .pc_val(pc),
    .src_ext(s_ext), .ext0(ext0), .ext1(ext1), .kind(d_kind),
    .addr(d_addr), .needs_ext(d_ext)
  );

  amr_cost u_cost (
    .src_mode(f_smode), .ad(f_ad), .dst_is_pc(f_dreg == PC_IDX),
    .src_ext(s_ext), .dst_ext(d_ext), .len_words(n_len), .cycles(n_cyc)
  );

  // next-state
  logic [RIDX_W-1:0] n_wbreg;
  assign n_wbreg = s_wb ? f_sreg : '0;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_kind  <= '0;
      src_reg   <= '0;
      src_addr  <= '0;
      src_imm   <= '0;
      dst_kind  <= 1'b0;
      dst_reg   <= '0;
      dst_addr  <= '0;
      wb_en     <= 1'b0;
      wb_reg    <= '0;
      wb_val    <= '0;
      len_words <= '0;
      cycles    <= '0;
    end else if (in_valid) begin
      src_kind  <= s_kind;
      src_reg   <= f_sreg;
      src_addr  <= s_addr;
      src_imm   <= s_imm;
      dst_kind  <= d_kind;
      dst_reg   <= f_dreg;
      dst_addr  <= d_addr;
      wb_en     <= s_wb;
      wb_reg    <= n_wbreg;
      wb_val    <= s_wbv;
      len_words <= n_len;
      cycles    <= n_cyc;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(src_addr) && $stable(dst_addr) && $stable(cycles) && !out_valid));

  // R5
  wb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (src_kind == 2'd1 && ((wb_val - src_addr) == DW'(1) || (wb_val - src_addr) == DW'(2))));

  // R6
  imm_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && src_kind == 2'd2) |-> (!wb_en && len_words >= 2'd2));

  // R10
  mem_dst_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dst_kind) |-> (cycles >= 3'd4 && len_words >= 2'd2));

  // R9
  reg_pair_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dst_kind && src_kind == 2'd0) |-> (cycles <= 3'd2 && len_words == 2'd1));

  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (len_words != 2'd0));
endmodule

// File: tb/amr_resolver_tb.sv
module amr_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] instr, pc, src_val, dst_val, ext0, ext1;
  logic        byte_op;
  logic        out_valid;
  logic [1:0]  src_kind;
  logic [3:0]  src_reg, dst_reg, wb_reg;
  logic [15:0] src_addr, src_imm, dst_addr, wb_val;
  logic        dst_kind, wb_en;
  logic [1:0]  len_words;
  logic [2:0]  cycles;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  amr_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .src_val(src_val), .dst_val(dst_val), .ext0(ext0), .ext1(ext1),
    .byte_op(byte_op), .out_valid(out_valid), .src_kind(src_kind),
    .src_reg(src_reg), .src_addr(src_addr), .src_imm(src_imm),
    .dst_kind(dst_kind), .dst_reg(dst_reg), .dst_addr(dst_addr),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_val(wb_val),
    .len_words(len_words), .cycles(cycles)
  );

  // expected values
  logic [1:0]  e_skind;
  logic [15:0] e_saddr, e_simm, e_daddr, e_wbv;
  logic        e_dkind, e_wb;
  logic [3:0]  e_wbreg;
  logic [1:0]  e_len;
  logic [2:0]  e_cyc;

  task automatic model();
    logic [3:0] sr, dr;
    logic [1:0] sm;
    logic       ad, sx;
    logic [15:0] xw, xl;
    sr = instr[11:8]; dr = instr[3:0]; sm = instr[5:4]; ad = instr[7];
    e_skind = 0; e_saddr = 0; e_simm = 0; e_wb = 0; e_wbreg = 0; e_wbv = 0;
    sx = (sm == 2'b01) || (sm == 2'b11 && sr == 0);
    case (sm)
      2'b00: e_skind = 0;
      2'b01: begin
        e_skind = 1;
        e_saddr = ext0 + ((sr == 0) ? pc + 16'd2 : (sr == 2) ? 16'd0 : src_val);
      end
      2'b10: begin
        e_skind = 1;
        e_saddr = (sr == 0) ? pc + 16'd2 : src_val;
      end
      default: begin
        if (sr == 0) begin
          e_skind = 2; e_simm = ext0;
        end else begin
          e_skind = 1; e_saddr = src_val; e_wb = 1; e_wbreg = sr;
          e_wbv = src_val + (byte_op ? 16'd1 : 16'd2);
        end
      end
    endcase
    e_dkind = ad;
    e_daddr = 0;
    if (ad) begin
      xw = sx ? ext1 : ext0;
      xl = pc + (sx ? 16'd4 : 16'd2);
      e_daddr = xw + ((dr == 0) ? xl : (dr == 2) ? 16'd0 : dst_val);
    end
    e_len = 2'(1 + int'(sx) + int'(ad));
    if (ad) e_cyc = (sm == 0) ? 3'd4 : (sm == 1) ? 3'd6 : 3'd5;
    else if (dr == 0) e_cyc = (sm == 0 || sm == 2) ? 3'd2 : 3'd3;
    else e_cyc = (sm == 0) ? 3'd1 : (sm == 1) ? 3'd3 : 3'd2;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h instr=%h", req, what, act, exp, instr);
    end
  endtask

  // drive at negedge, registered at posedge, compare at next negedge
  task automatic run_one(input logic [15:0] i, input logic [15:0] p, input logic [15:0] sv,
                         input logic [15:0] dv, input logic [15:0] x0, input logic [15:0] x1,
                         input logic bo);
    instr = i; pc = p; src_val = sv; dst_val = dv; ext0 = x0; ext1 = x1; byte_op = bo;
    in_valid = 1'b1;
    model();
    @(negedge clk);
    chk("R2", "out_valid", 32'(out_valid), 32'd1);
    chk("R3", "src_kind", 32'(src_kind), 32'(e_skind));
    chk("R3", "src_reg", 32'(src_reg), 32'(instr[11:8]));
    chk("R4", "src_addr", 32'(src_addr), 32'(e_saddr));
    chk("R6", "src_imm", 32'(src_imm), 32'(e_simm));
    chk("R5", "wb_en", 32'(wb_en), 32'(e_wb));
    chk("R5", "wb_reg", 32'(wb_reg), 32'(e_wbreg));
    chk("R5", "wb_val", 32'(wb_val), 32'(e_wbv));
    chk("R7", "dst_kind", 32'(dst_kind), 32'(e_dkind));
    chk("R7", "dst_reg", 32'(dst_reg), 32'(instr[3:0]));
    chk("R7", "dst_addr", 32'(dst_addr), 32'(e_daddr));
    chk("R8", "len_words", 32'(len_words), 32'(e_len));
    chk("R9", "cycles", 32'(cycles), 32'(e_cyc));
  endtask

  function automatic logic [15:0] mk(input int sr, input int ad, input int sm, input int dr);
    return {4'h4, 4'(sr), 1'(ad), 1'b0, 2'(sm), 4'(dr)};
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = 0; pc = 0; src_val = 0; dst_val = 0;
    ext0 = 0; ext1 = 0; byte_op = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "outputs", 32'({src_kind, src_reg, dst_kind, dst_reg, wb_en, wb_reg, len_words, cycles}), 0);
    chk("R1", "addrs", {src_addr, dst_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "after release", 32'({out_valid, src_kind, len_words, cycles}), 0);

    // directed corners
    run_one(mk(5, 0, 0, 7), 16'h1000, 16'hAAAA, 16'hBBBB, 0, 0, 0);                 // R9 reg/reg =1
    run_one(mk(6, 0, 2, 4), 16'h1000, 16'h0203, 16'h0, 0, 0, 0);                    // R3 indirect
    run_one(mk(0, 0, 2, 4), 16'h1000, 16'h0, 16'h0, 0, 0, 0);                       // R3 @PC -> pc+2
    run_one(mk(5, 0, 1, 4), 16'h2000, 16'h020A, 0, 16'h0002, 0, 0);                 // R4 indexed
    run_one(mk(0, 0, 1, 4), 16'h2000, 16'h0, 0, 16'h0100, 0, 0);                    // R4 symbolic
    run_one(mk(2, 0, 1, 4), 16'h2000, 16'hFFFF, 0, 16'h0206, 0, 0);                 // R4 absolute
    run_one(mk(4, 0, 3, 7), 16'h2000, 16'h0200, 0, 0, 0, 0);                        // R5 word step 2
    run_one(mk(5, 0, 3, 7), 16'h2000, 16'h020A, 0, 0, 0, 1);                        // R5 byte step 1
    run_one(mk(4, 0, 3, 7), 16'h2000, 16'hFFFF, 0, 0, 0, 0);                        // R5 wrap
    run_one(mk(0, 0, 3, 4), 16'h3000, 0, 0, 16'h3575, 0, 0);                        // R6 immediate
    run_one(mk(0, 1, 3, 4), 16'h3000, 0, 16'h0200, 16'h3575, 16'h0004, 0);          // R7 ext order
    run_one(mk(5, 1, 1, 0), 16'h3000, 16'h0100, 0, 16'h0002, 16'h0010, 0);          // R7 symbolic dst pc+4
    run_one(mk(5, 1, 0, 2), 16'h3000, 16'h0100, 16'hFFFF, 16'h0201, 16'h0, 0);      // R7 absolute dst
    run_one(mk(5, 1, 0, 0), 16'h3000, 0, 0, 16'h0040, 0, 0);                        // R7 symbolic dst pc+2
    run_one(mk(2, 1, 1, 2), 16'h3000, 0, 0, 16'h0206, 16'h0201, 0);                 // R8 len 3, R10 cycles 6
    run_one(mk(5, 1, 2, 6), 16'h3000, 16'h10, 16'h20, 16'h4, 0, 0);                 // R10 cycles 5
    run_one(mk(5, 0, 0, 0), 16'h3000, 0, 0, 0, 0, 0);                               // R11 =2
    run_one(mk(9, 0, 3, 0), 16'h3000, 16'h50, 0, 0, 0, 0);                          // R11 =3
    run_one(mk(0, 0, 3, 0), 16'h3000, 0, 0, 16'h2AE, 0, 0);                         // R11 imm =3
    run_one(mk(8, 0, 2, 0), 16'h3000, 16'h60, 0, 0, 0, 0);                          // R11 =2
    run_one(mk(6, 0, 1, 0), 16'h3000, 16'h60, 0, 2, 0, 0);                          // R11 =3

    // R2 hold: idle cycle with changed inputs
    begin
      logic [15:0] sa, da; logic [2:0] cy;
      sa = src_addr; da = dst_addr; cy = cycles;
      in_valid = 1'b0; instr = mk(3, 1, 1, 5); src_val = 16'h7777; ext0 = 16'h1111;
      @(negedge clk);
      chk("R2", "out_valid idle", 32'(out_valid), 0);
      chk("R2", "hold", {sa, da}, {src_addr, dst_addr});
      chk("R2", "hold cycles", 32'(cycles), 32'(cy));
    end

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [15:0] r;
      r = 16'($urandom());
      if ((k % 4) == 0) r[11:8] = 4'(($urandom() % 3));
      if ((k % 5) == 0) r[3:0] = 4'(($urandom() % 3));
      run_one(r, 16'($urandom()) & 16'hFFFE, 16'($urandom()), 16'($urandom()),
              16'($urandom()), 16'($urandom()), 1'($urandom()));
      if ((k % 37) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2", "out_valid idle", 32'(out_valid), 0);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule